// File: doc/BRIEF.md
# Machine-Mode CSR Execution Unit

This block carries out the control and status register instructions of a core that runs only in machine mode, together with the two trap-return forms. The core's decoder hands it the instruction class, the three-bit function code, the twelve-bit register address, the five-bit source field (a register index or an immediate), the source register value and the destination index, and pulses a start strobe. The unit then takes a fixed four-cycle sequence. It decides whether the instruction is legal in the first cycle, reads the old register value in the second, forms the new value in the third and commits in the fourth. In the commit cycle it presents the destination write, a trap flag or a redirect.

It holds the small register file that a machine-only core needs: the status word with its interrupt-enable pair and fixed previous-privilege field, the ISA word, the trap vector, the scratch register, the exception PC, the cause and value registers, the enable and pending words, a free-running cycle counter, and the read-only identity registers. There is no supervisor state, so the supervisor return is always an illegal instruction. Trap entry itself belongs to the core: the unit only reports the trap.

Top module: `mcsr_unit`

## Requirements
- R1: After a start accepted in idle, busy is high for exactly four cycles and done is high only in the fourth. A start seen while busy is ignored and changes neither the running instruction nor any register.
- R2: With class 2'b00 and funct3 3'b001 (register) or 3'b101 (immediate), the destination receives the old value and the register receives the operand. A destination index of 0 suppresses the destination write but the register is still written.
- R3: funct3 3'b010 ORs the operand into the register and funct3 3'b011 stores old AND NOT operand. Both return the old value to the destination.
- R4: funct3 3'b101, 3'b110 and 3'b111 use the five-bit source field, zero-extended, as the operand in place of the register value.
- R5: A set or clear (funct3 x10 or x11) whose source field is zero performs no register write, so it never traps on a read-only register.
- R6: The implemented addresses are 0x300 status, 0x301 ISA, 0x304 enable, 0x305 vector, 0x340 scratch, 0x341 exception PC, 0x342 cause, 0x343 trap value, 0x344 pending, 0xB00 cycle, and 0xF11 to 0xF14 identity. Any other address raises illegal, writes no destination and changes no register.
- R7: An address with bits [11:10] equal to 2'b11 is read-only. Any instruction that would write it raises illegal.
- R8: funct3 3'b000 and 3'b100 under class 2'b00 raise illegal.
- R9: Class 2'b01 (machine return) copies the previous-enable bit into the enable bit, sets the previous-enable bit to 1, and raises redirect with redirect_pc equal to the exception PC. It writes no destination.
- R10: Class 2'b10 (supervisor return) and class 2'b11 raise illegal. The status word reads with enable at bit 3, previous enable at bit 7, bits [12:11] fixed at 2'b11, and every other bit zero.
- R11: Bits [1:0] of the vector and exception PC always read zero. The enable word keeps only bits 3, 7 and 11. The ISA word reads 0x40000100 and the pending word reads zero, and both ignore writes.
- R12: The cycle counter clears in reset and advances by one on every later clock, and a write replaces it. A read returns the counter value held during the cycle after the start edge.
- R13: During and after reset, busy, done, illegal, rd_we, redirect and every output data field are zero, and all writable registers read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (taken only when idle) |
| sys_kind | input | 2 | 00 register op, 01 machine return, 10 supervisor return, 11 reserved |
| funct3 | input | 3 | Function code of the register instruction |
| csr_addr | input | 12 | Register address |
| rs1_field | input | 5 | Source index field, also the immediate |
| rs1_val | input | XLEN | Source register value |
| rd_idx | input | 5 | Destination index |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Commit cycle of the instruction |
| illegal | output | 1 | Illegal-instruction trap, valid with done |
| rd_we | output | 1 | Destination write enable, valid with done |
| rd_waddr | output | 5 | Destination index |
| rd_wdata | output | XLEN | Old register value for the destination |
| redirect | output | 1 | Machine return taken, valid with done |
| redirect_pc | output | XLEN | Next fetch address on redirect |

## Verification
The bench builds the unit at its defaults: XLEN 32, the cycle counter present, enable mask 0x888 and hart number 0. With those values the counter address is live, so timed counter reads and counter overwrites can be compared against an edge count kept in the bench. The three-bit enable mask leaves bits that must drop on a write of all ones. A 32-bit word also leaves every status bit outside the three defined fields open to a stray write.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

  localparam logic [1:0] KIND_CSR  = 2'b00;
  localparam logic [1:0] KIND_MRET = 2'b01;

  localparam logic [11:0] A_MSTATUS  = 12'h300;
  localparam logic [11:0] A_MISA     = 12'h301;
  localparam logic [11:0] A_MIE      = 12'h304;
  localparam logic [11:0] A_MTVEC    = 12'h305;
  localparam logic [11:0] A_MSCRATCH = 12'h340;
  localparam logic [11:0] A_MEPC     = 12'h341;
  localparam logic [11:0] A_MCAUSE   = 12'h342;
  localparam logic [11:0] A_MTVAL    = 12'h343;
  localparam logic [11:0] A_MIP      = 12'h344;
  localparam logic [11:0] A_MCYCLE   = 12'hB00;
  localparam logic [11:0] A_MVENDOR  = 12'hF11;
  localparam logic [11:0] A_MARCH    = 12'hF12;
  localparam logic [11:0] A_MIMP     = 12'hF13;
  localparam logic [11:0] A_MHART    = 12'hF14;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_MSTATUS, SEL_MISA, SEL_MIE, SEL_MTVEC, SEL_MSCRATCH,
    SEL_MEPC, SEL_MCAUSE, SEL_MTVAL, SEL_MIP, SEL_MCYCLE,
    SEL_MVENDOR, SEL_MARCH, SEL_MIMP, SEL_MHART
  } csr_sel_e;

  typedef enum logic [1:0] {OP_NONE, OP_WRITE, OP_SET, OP_CLEAR} csr_op_e;

  typedef struct packed {
    csr_sel_e sel;
    csr_op_e  op;
    logic     wr_en;
    logic     rd_we;
    logic     mret;
    logic     illegal;
  } csr_dec_t;

endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
  import mcsr_pkg::*;
#(
  parameter bit HAS_CYCLE = 1'b1
) (
  input  logic [1:0]  kind,
  input  logic [2:0]  funct3,
  input  logic [11:0] addr,
  input  logic [4:0]  rs1_field,
  input  logic [4:0]  rd_idx,
  output logic        use_imm,
  output csr_dec_t    dec
);

  csr_sel_e sel_base;
  csr_sel_e sel;
  csr_op_e  op;
  logic     cyc_hit;
  logic     wants_wr;
  logic     read_only;
  logic     bad;

  always_comb begin
    unique case (addr)
      A_MSTATUS:  sel_base = SEL_MSTATUS;
      A_MISA:     sel_base = SEL_MISA;
      A_MIE:      sel_base = SEL_MIE;
      A_MTVEC:    sel_base = SEL_MTVEC;
      A_MSCRATCH: sel_base = SEL_MSCRATCH;
      A_MEPC:     sel_base = SEL_MEPC;
      A_MCAUSE:   sel_base = SEL_MCAUSE;
      A_MTVAL:    sel_base = SEL_MTVAL;
      A_MIP:      sel_base = SEL_MIP;
      A_MVENDOR:  sel_base = SEL_MVENDOR;
      A_MARCH:    sel_base = SEL_MARCH;
      A_MIMP:     sel_base = SEL_MIMP;
      A_MHART:    sel_base = SEL_MHART;
      default:    sel_base = SEL_NONE;
    endcase
  end

  generate
    if (HAS_CYCLE) begin : g_cyc
      assign cyc_hit = (addr == A_MCYCLE);
    end else begin : g_nocyc
      assign cyc_hit = 1'b0;
    end
  endgenerate

  assign sel = cyc_hit ? SEL_MCYCLE : sel_base;

  always_comb begin
    unique case (funct3[1:0])
      2'b01:   op = OP_WRITE;
      2'b10:   op = OP_SET;
      2'b11:   op = OP_CLEAR;
      default: op = OP_NONE;
    endcase
  end

  assign use_imm   = funct3[2];
  assign wants_wr  = (op == OP_WRITE) || (rs1_field != 5'd0);
  assign read_only = (addr[11:10] == 2'b11);
  assign bad       = (op == OP_NONE) || (sel == SEL_NONE) || (read_only && wants_wr);

  always_comb begin
    dec     = '0;
    dec.sel = sel;
    dec.op  = op;
    unique case (kind)
      KIND_CSR: begin
        dec.illegal = bad;
        dec.wr_en   = !bad && wants_wr;
        dec.rd_we   = !bad && (rd_idx != 5'd0);
      end
      KIND_MRET: dec.mret = 1'b1;
      default:   dec.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/mcsr_file.sv
module mcsr_file
  import mcsr_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter bit              HAS_CYCLE = 1'b1,
  parameter logic [XLEN-1:0] MISA_VAL  = 32'h4000_0100,
  parameter logic [XLEN-1:0] MIE_MASK  = 32'h0000_0888,
  parameter logic [XLEN-1:0] HART_ID   = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  csr_sel_e        rd_sel,
  output logic [XLEN-1:0] rdata,
  input  logic            wr_en,
  input  csr_sel_e        wr_sel,
  input  logic [XLEN-1:0] wr_data,
  input  logic            mret_en,
  output logic [XLEN-1:0] mepc_o
);

  localparam logic [XLEN-1:0] ALIGN = {{(XLEN-2){1'b1}}, 2'b00};

  logic            st_mie, st_mpie;
  logic [XLEN-1:0] ien_q, tvec_q, scratch_q, epc_q, cause_q, tval_q;
  logic [XLEN-1:0] cyc_val;
  logic [XLEN-1:0] status_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_mie    <= 1'b0;
      st_mpie   <= 1'b0;
      ien_q     <= '0;
      tvec_q    <= '0;
      scratch_q <= '0;
      epc_q     <= '0;
      cause_q   <= '0;
      tval_q    <= '0;
    end else if (mret_en) begin
      st_mie  <= st_mpie;
      st_mpie <= 1'b1;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_MSTATUS: begin
          st_mie  <= wr_data[3];
          st_mpie <= wr_data[7];
        end
        SEL_MIE:      ien_q     <= wr_data & MIE_MASK;
        SEL_MTVEC:    tvec_q    <= wr_data & ALIGN;
        SEL_MSCRATCH: scratch_q <= wr_data;
        SEL_MEPC:     epc_q     <= wr_data & ALIGN;
        SEL_MCAUSE:   cause_q   <= wr_data;
        SEL_MTVAL:    tval_q    <= wr_data;
        default: ;
      endcase
    end
  end

  generate
    if (HAS_CYCLE) begin : g_cycle
      logic [XLEN-1:0] cnt_q;
      logic            cnt_we;
      assign cnt_we = wr_en && (wr_sel == SEL_MCYCLE);
      always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (cnt_we) cnt_q <= wr_data;
        else             cnt_q <= cnt_q + 1'b1;
      end
      assign cyc_val = cnt_q;

      p_cycle_step_r12: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cnt_we)) |-> (cnt_q == $past(cnt_q) + 1'b1));
    end else begin : g_nocycle
      assign cyc_val = '0;
    end
  endgenerate

  always_comb begin
    status_rd        = '0;
    status_rd[12:11] = 2'b11;
    status_rd[7]     = st_mpie;
    status_rd[3]     = st_mie;
  end

  always_comb begin
    unique case (rd_sel)
      SEL_MSTATUS:  rdata = status_rd;
      SEL_MISA:     rdata = MISA_VAL;
      SEL_MIE:      rdata = ien_q;
      SEL_MTVEC:    rdata = tvec_q;
      SEL_MSCRATCH: rdata = scratch_q;
      SEL_MEPC:     rdata = epc_q;
      SEL_MCAUSE:   rdata = cause_q;
      SEL_MTVAL:    rdata = tval_q;
      SEL_MCYCLE:   rdata = cyc_val;
      SEL_MHART:    rdata = HART_ID;
      default:      rdata = '0;
    endcase
  end

  assign mepc_o = epc_q;

  p_ro_not_written_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !(wr_sel inside {SEL_MVENDOR, SEL_MARCH, SEL_MIMP, SEL_MHART}));

  p_mret_restore_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mret_en)) |-> (st_mpie && (st_mie == $past(st_mpie))));

  p_aligned_r11: assert property (@(posedge clk) disable iff (rst)
    (tvec_q[1:0] == 2'b00) && (epc_q[1:0] == 2'b00));

endmodule

// File: rtl/mcsr_seq.sv
module mcsr_seq
  import mcsr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  csr_dec_t        dec_in,
  input  logic            use_imm,
  input  logic [4:0]      rs1_field,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [4:0]      rd_idx,
  output csr_sel_e        f_rd_sel,
  input  logic [XLEN-1:0] f_rdata,
  output logic            f_wr_en,
  output csr_sel_e        f_wr_sel,
  output logic [XLEN-1:0] f_wr_data,
  output logic            f_mret,
  input  logic [XLEN-1:0] f_mepc,
  output logic            busy,
  output logic            done,
  output logic            illegal,
  output logic            rd_we,
  output logic [4:0]      rd_waddr,
  output logic [XLEN-1:0] rd_wdata,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_pc
);

  typedef enum logic [2:0] {ST_IDLE, ST_READ, ST_CALC, ST_COMMIT, ST_DONE} st_e;

  st_e             st_q;
  csr_dec_t        dec_q;
  logic [XLEN-1:0] opnd_q, old_q, new_q, alu;
  logic [4:0]      rd_q;
  logic            accept;
  logic            commit;

  assign accept = start && (st_q == ST_IDLE);
  assign commit = (st_q == ST_COMMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:   if (accept) st_q <= ST_READ;
        ST_READ:   st_q <= ST_CALC;
        ST_CALC:   st_q <= ST_COMMIT;
        ST_COMMIT: st_q <= ST_DONE;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (dec_q.op)
      OP_WRITE: alu = opnd_q;
      OP_SET:   alu = old_q | opnd_q;
      OP_CLEAR: alu = old_q & ~opnd_q;
      default:  alu = old_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_q  <= '0;
      opnd_q <= '0;
      rd_q   <= '0;
      old_q  <= '0;
      new_q  <= '0;
    end else begin
      if (accept) begin
        dec_q  <= dec_in;
        opnd_q <= use_imm ? {{(XLEN-5){1'b0}}, rs1_field} : rs1_val;
        rd_q   <= rd_idx;
      end
      if (st_q == ST_READ) old_q <= f_rdata;
      if (st_q == ST_CALC) new_q <= alu;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !commit) begin
      done        <= 1'b0;
      illegal     <= 1'b0;
      rd_we       <= 1'b0;
      rd_waddr    <= '0;
      rd_wdata    <= '0;
      redirect    <= 1'b0;
      redirect_pc <= '0;
    end else begin
      done        <= 1'b1;
      illegal     <= dec_q.illegal;
      rd_we       <= dec_q.rd_we;
      rd_waddr    <= dec_q.rd_we ? rd_q : 5'd0;
      rd_wdata    <= dec_q.rd_we ? old_q : '0;
      redirect    <= dec_q.mret;
      redirect_pc <= dec_q.mret ? f_mepc : '0;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign f_rd_sel  = dec_q.sel;
  assign f_wr_sel  = dec_q.sel;
  assign f_wr_en   = commit && dec_q.wr_en;
  assign f_wr_data = new_q;
  assign f_mret    = commit && dec_q.mret;

  p_four_cycles_r1: assert property (@(posedge clk) disable iff (rst)
    done |-> (busy && $past(busy, 1) && $past(busy, 2) && $past(busy, 3) && !$past(busy, 4)));

  p_trap_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    (f_wr_en || f_mret) |-> !dec_q.illegal);

endmodule

// File: rtl/mcsr_unit.sv
module mcsr_unit
  import mcsr_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter bit              HAS_CYCLE = 1'b1,
  parameter logic [XLEN-1:0] MISA_VAL  = 32'h4000_0100,
  parameter logic [XLEN-1:0] MIE_MASK  = 32'h0000_0888,
  parameter logic [XLEN-1:0] HART_ID   = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      sys_kind,
  input  logic [2:0]      funct3,
  input  logic [11:0]     csr_addr,
  input  logic [4:0]      rs1_field,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [4:0]      rd_idx,
  output logic            busy,
  output logic            done,
  output logic            illegal,
  output logic            rd_we,
  output logic [4:0]      rd_waddr,
  output logic [XLEN-1:0] rd_wdata,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_pc
);

  csr_dec_t        dec;
  logic            use_imm;
  csr_sel_e        rd_sel, wr_sel;
  logic [XLEN-1:0] rdata, wr_data, mepc;
  logic            wr_en, mret_en;

  mcsr_decode #(.HAS_CYCLE(HAS_CYCLE)) u_dec (
    .kind      (sys_kind),
    .funct3    (funct3),
    .addr      (csr_addr),
    .rs1_field (rs1_field),
    .rd_idx    (rd_idx),
    .use_imm   (use_imm),
    .dec       (dec)
  );

  mcsr_seq #(.XLEN(XLEN)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .dec_in      (dec),
    .use_imm     (use_imm),
    .rs1_field   (rs1_field),
    .rs1_val     (rs1_val),
    .rd_idx      (rd_idx),
    .f_rd_sel    (rd_sel),
    .f_rdata     (rdata),
    .f_wr_en     (wr_en),
    .f_wr_sel    (wr_sel),
    .f_wr_data   (wr_data),
    .f_mret      (mret_en),
    .f_mepc      (mepc),
    .busy        (busy),
    .done        (done),
    .illegal     (illegal),
    .rd_we       (rd_we),
    .rd_waddr    (rd_waddr),
    .rd_wdata    (rd_wdata),
    .redirect    (redirect),
    .redirect_pc (redirect_pc)
  );

  mcsr_file #(
    .XLEN(XLEN), .HAS_CYCLE(HAS_CYCLE), .MISA_VAL(MISA_VAL),
    .MIE_MASK(MIE_MASK), .HART_ID(HART_ID)
  ) u_file (
    .clk     (clk),
    .rst     (rst),
    .rd_sel  (rd_sel),
    .rdata   (rdata),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .mret_en (mret_en),
    .mepc_o  (mepc)
  );

  p_trap_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!rd_we && !redirect && done));

endmodule

// File: tb/mcsr_unit_tb.sv
module mcsr_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  sys_kind = 2'b00;
  logic [2:0]  funct3 = 3'b000;
  logic [11:0] csr_addr = 12'h000;
  logic [4:0]  rs1_field = 5'd0;
  logic [31:0] rs1_val = 32'h0;
  logic [4:0]  rd_idx = 5'd0;
  logic        busy, done, illegal, rd_we, redirect;
  logic [4:0]  rd_waddr;
  logic [31:0] rd_wdata, redirect_pc;

  mcsr_unit u_dut (
    .clk(clk), .rst(rst), .start(start), .sys_kind(sys_kind), .funct3(funct3),
    .csr_addr(csr_addr), .rs1_field(rs1_field), .rs1_val(rs1_val), .rd_idx(rd_idx),
    .busy(busy), .done(done), .illegal(illegal), .rd_we(rd_we), .rd_waddr(rd_waddr),
    .rd_wdata(rd_wdata), .redirect(redirect), .redirect_pc(redirect_pc)
  );

  always #10 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  int edge_cnt = 0;

  always @(posedge clk) begin
    if (rst) edge_cnt <= 0;
    else     edge_cnt <= edge_cnt + 1;
  end

  // reference state
  bit          m_mie, m_mpie;
  logic [31:0] m_ien, m_tvec, m_scr, m_epc, m_cause, m_tval;
  logic [31:0] m_cyc_val;
  int          m_cyc_edge;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit m_known(input logic [11:0] a);
    return a inside {12'h300, 12'h301, 12'h304, 12'h305, 12'h340, 12'h341, 12'h342,
                     12'h343, 12'h344, 12'hB00, 12'hF11, 12'hF12, 12'hF13, 12'hF14};
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a, input int kc);
    case (a)
      12'h300: return 32'h1800 | (32'(m_mpie) << 7) | (32'(m_mie) << 3);
      12'h301: return 32'h4000_0100;
      12'h304: return m_ien;
      12'h305: return m_tvec;
      12'h340: return m_scr;
      12'h341: return m_epc;
      12'h342: return m_cause;
      12'h343: return m_tval;
      12'hB00: return m_cyc_val + 32'(kc - m_cyc_edge);
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_write(input logic [11:0] a, input logic [31:0] v, input int at_edge);
    case (a)
      12'h300: begin m_mie = v[3]; m_mpie = v[7]; end
      12'h304: m_ien   = v & 32'h888;
      12'h305: m_tvec  = v & 32'hFFFF_FFFC;
      12'h340: m_scr   = v;
      12'h341: m_epc   = v & 32'hFFFF_FFFC;
      12'h342: m_cause = v;
      12'h343: m_tval  = v;
      12'hB00: begin m_cyc_val = v; m_cyc_edge = at_edge; end
      default: ;
    endcase
  endtask

  // Issue one instruction, compare every cycle against the reference model.
  task automatic run(input logic [1:0] k, input logic [2:0] f3, input logic [11:0] a,
                     input logic [4:0] rf, input logic [31:0] rv, input logic [4:0] rd,
                     input bit poke, input string req);
    int          kc;
    bit          tim_ok;
    bit          ill, wants, ro;
    logic [31:0] old, opnd, nv, e_data, e_pc;
    bit          e_we, e_redir;
    @(negedge clk);
    sys_kind = k; funct3 = f3; csr_addr = a; rs1_field = rf; rs1_val = rv; rd_idx = rd;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    kc = edge_cnt;
    if (poke) begin
      // R1: start held while busy with different operands must be ignored
      start = 1'b1; funct3 = 3'b001; rs1_val = ~rv; rd_idx = 5'd9;
    end else begin
      start = 1'b0;
    end
    wants = (f3[1:0] == 2'b01) || (rf != 5'd0);
    ro    = (a[11:10] == 2'b11);
    if (k == 2'b00)      ill = (f3[1:0] == 2'b00) || !m_known(a) || (ro && wants);
    else if (k == 2'b01) ill = 1'b0;
    else                 ill = 1'b1;
    old     = m_read(a, kc);
    opnd    = f3[2] ? {27'd0, rf} : rv;
    e_we    = !ill && (k == 2'b00) && (rd != 5'd0);
    e_data  = e_we ? old : 32'h0;
    e_redir = (k == 2'b01);
    e_pc    = e_redir ? m_epc : 32'h0;
    tim_ok  = 1'b1;
    for (int i = 0; i < 3; i++) begin
      if (i > 0) @(negedge clk);
      if (i == 1) start = 1'b0;
      if (!(busy && !done && !illegal && !rd_we && !redirect)) tim_ok = 1'b0;
    end
    @(negedge clk);
    if (!(busy && done)) tim_ok = 1'b0;
    chk(illegal == ill, req, "illegal flag", 32'(illegal), 32'(ill));
    chk(rd_we == e_we && rd_waddr == (e_we ? rd : 5'd0), req, "dest enable/index",
        {rd_waddr, 26'd0, rd_we}, {(e_we ? rd : 5'd0), 26'd0, e_we});
    chk(rd_wdata == e_data, req, "dest data", rd_wdata, e_data);
    chk(redirect == e_redir && redirect_pc == e_pc, req, "redirect pc", redirect_pc, e_pc);
    @(negedge clk);
    if (busy || done) tim_ok = 1'b0;
    chk(tim_ok, "R1", "four-cycle busy/done shape", 32'(tim_ok), 32'd1);
    if (!ill && k == 2'b00 && wants) begin
      case (f3[1:0])
        2'b01:   nv = opnd;
        2'b10:   nv = old | opnd;
        default: nv = old & ~opnd;
      endcase
      m_write(a, nv, kc + 3);
    end else if (!ill && k == 2'b01) begin
      m_mie  = m_mpie;
      m_mpie = 1'b1;
    end
  endtask

  // read via set with zero source (no write)
  task automatic rd_csr(input logic [11:0] a, input string req);
    run(2'b00, 3'b010, a, 5'd0, 32'hDEAD_BEEF, 5'd7, 1'b0, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    m_mie = 0; m_mpie = 0; m_ien = 0; m_tvec = 0; m_scr = 0; m_epc = 0;
    m_cause = 0; m_tval = 0; m_cyc_val = 0; m_cyc_edge = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R13: reset state at the ports
    chk(!busy && !done && !illegal && !rd_we && !redirect && rd_wdata == 0 && redirect_pc == 0
        && rd_waddr == 0, "R13", "outputs in reset", {busy, done, illegal, rd_we, redirect}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done, "R13", "idle after reset", {busy, done}, 0);
    rd_csr(12'h340, "R13");
    rd_csr(12'h300, "R10");
    rd_csr(12'h301, "R11");

    // R2: register write/swap, rd=x0 suppression
    run(2'b00, 3'b001, 12'h340, 5'd3, 32'hA5A5_5A5A, 5'd5, 1'b0, "R2");
    run(2'b00, 3'b001, 12'h340, 5'd3, 32'h1234_5678, 5'd0, 1'b0, "R2");
    rd_csr(12'h340, "R2");
    // R3: set / clear
    run(2'b00, 3'b010, 12'h340, 5'd4, 32'h0F00_00F0, 5'd6, 1'b0, "R3");
    run(2'b00, 3'b011, 12'h340, 5'd4, 32'h1030_0070, 5'd6, 1'b0, "R3");
    rd_csr(12'h342, "R3");
    run(2'b00, 3'b010, 12'h342, 5'd8, 32'h8000_0003, 5'd1, 1'b0, "R3");
    run(2'b00, 3'b011, 12'h342, 5'd8, 32'h0000_0001, 5'd1, 1'b0, "R3");
    // R4: immediate forms
    run(2'b00, 3'b101, 12'h343, 5'd31, 32'hFFFF_FFFF, 5'd2, 1'b0, "R4");
    run(2'b00, 3'b110, 12'h340, 5'd21, 32'h0, 5'd2, 1'b0, "R4");
    run(2'b00, 3'b111, 12'h340, 5'd5, 32'hFFFF_FFFF, 5'd2, 1'b0, "R4");
    rd_csr(12'h343, "R4");
    // R5: zero-source set/clear on read-only registers
    rd_csr(12'hF14, "R5");
    run(2'b00, 3'b011, 12'hF11, 5'd0, 32'hFFFF_FFFF, 5'd3, 1'b0, "R5");
    run(2'b00, 3'b110, 12'hF12, 5'd0, 32'h0, 5'd3, 1'b0, "R5");
    // R7: write attempts to read-only
    run(2'b00, 3'b001, 12'hF14, 5'd0, 32'h55, 5'd3, 1'b0, "R7");
    run(2'b00, 3'b010, 12'hF13, 5'd2, 32'h55, 5'd3, 1'b0, "R7");
    // R6: unknown addresses leave state alone
    run(2'b00, 3'b001, 12'h7C0, 5'd1, 32'hCAFE_F00D, 5'd4, 1'b0, "R6");
    run(2'b00, 3'b001, 12'h180, 5'd1, 32'hCAFE_F00D, 5'd4, 1'b0, "R6");
    run(2'b00, 3'b010, 12'hC00, 5'd0, 32'h0, 5'd4, 1'b0, "R6");
    rd_csr(12'h340, "R6");
    // R8: reserved function codes
    run(2'b00, 3'b000, 12'h340, 5'd1, 32'h1, 5'd4, 1'b0, "R8");
    run(2'b00, 3'b100, 12'h340, 5'd1, 32'h1, 5'd4, 1'b0, "R8");
    rd_csr(12'h340, "R8");
    // R10/R11: status layout and masked fields
    run(2'b00, 3'b001, 12'h300, 5'd1, 32'hFFFF_FFFF, 5'd4, 1'b0, "R10");
    rd_csr(12'h300, "R10");
    run(2'b00, 3'b001, 12'h304, 5'd1, 32'hFFFF_FFFF, 5'd4, 1'b0, "R11");
    run(2'b00, 3'b001, 12'h305, 5'd1, 32'h0000_1237, 5'd4, 1'b0, "R11");
    run(2'b00, 3'b001, 12'h301, 5'd1, 32'h0, 5'd4, 1'b0, "R11");
    run(2'b00, 3'b001, 12'h344, 5'd1, 32'hFFFF_FFFF, 5'd4, 1'b0, "R11");
    rd_csr(12'h301, "R11");
    rd_csr(12'h344, "R11");
    rd_csr(12'h304, "R11");
    rd_csr(12'h305, "R11");
    // R9: machine return
    run(2'b00, 3'b001, 12'h341, 5'd1, 32'h0000_2003, 5'd4, 1'b0, "R9");
    run(2'b00, 3'b001, 12'h300, 5'd1, 32'h0000_0080, 5'd0, 1'b0, "R9");
    run(2'b01, 3'b000, 12'h302, 5'd0, 32'h0, 5'd6, 1'b0, "R9");
    rd_csr(12'h300, "R9");
    run(2'b00, 3'b001, 12'h300, 5'd1, 32'h0000_0008, 5'd0, 1'b0, "R9");
    run(2'b01, 3'b000, 12'h302, 5'd0, 32'h0, 5'd0, 1'b0, "R9");
    rd_csr(12'h300, "R9");
    // R10: supervisor return and reserved class
    run(2'b10, 3'b000, 12'h102, 5'd0, 32'h0, 5'd0, 1'b0, "R10");
    run(2'b11, 3'b001, 12'h340, 5'd1, 32'h9, 5'd2, 1'b0, "R10");
    rd_csr(12'h300, "R10");
    // R12: cycle counter
    rd_csr(12'hB00, "R12");
    repeat (7) @(negedge clk);
    rd_csr(12'hB00, "R12");
    run(2'b00, 3'b001, 12'hB00, 5'd1, 32'd1000, 5'd5, 1'b0, "R12");
    rd_csr(12'hB00, "R12");
    // R1: start held during busy is ignored
    run(2'b00, 3'b001, 12'h340, 5'd1, 32'h0000_1111, 5'd2, 1'b1, "R1");
    rd_csr(12'h340, "R1");

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule